// File: doc/BRIEF.md
# Shift-Register Polynomial Ring Multiplier

This block multiplies a polynomial with small coefficients, a(x), by a polynomial with large coefficients, b(x), and reduces the product modulo a monic quotient polynomial of degree N. The quotient polynomial is picked at run time from three choices: x^N+1, x^N-1 and x^N-x-1. The small operand is held in an N-entry shift register. After each compute step that register is replaced by a(x)·x mod the quotient polynomial, and the arithmetic inside it is done modulo the small modulus P. One large coefficient is consumed per compute step. N parallel multiply-accumulate lanes add b_i times the current register contents into N accumulators, and each accumulator is reduced modulo Q every cycle.

A multiplication runs in three phases. The load phase fills the register ALPHA coefficients per beat. The compute phase takes N beats of b. The readout phase presents GAMMA result coefficients per beat. All three data paths are valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. The block deasserts ready to hold off a source. When the sink holds ready low, the block keeps its presented result beat unchanged. The start input, the mode input and the done output are plain control pins.

Top module: `polymul_xnet`

## Requirements
- R1: After reset the block is idle: load_ready, b_ready, r_valid and done are all 0.
- R2: Start high while idle samples mode and enters the load phase. load_ready is then 1 until N/ALPHA load beats have been accepted. In load beat k, lane j at bits [j*PW +: PW] carries a_{k*ALPHA+j} as a signed balanced value mod P. The beats are accepted in order, and a cycle with load_valid low does not advance.
- R3: After loading, b_ready is 1 until N beats of b have been accepted. Beat i is b_i, a signed balanced value mod Q. A cycle with b_valid low does not advance the computation.
- R4: Mode code 0 selects x^N+1. At each step the top coefficient is negated and enters position 0. Mode code 3 behaves as code 0.
- R5: Mode code 1 selects x^N-1. At each step the top coefficient enters position 0 unchanged.
- R6: Mode code 2 selects x^N-x-1. At each step the top coefficient enters position 0, and position 1 receives (a_0 + top) reduced to the balanced range mod P.
- R7: The result is r = sum over i of b_i · lift(x^i·a(x) mod (P, p(x))), reduced mod Q. It is presented as N/GAMMA beats. In readout beat k, lane g at bits [g*QW +: QW] carries r_{k*GAMMA+g}. r_data stays stable while r_valid is 1 and r_ready is 0.
- R8: done is 1 for exactly one cycle, the cycle after the last readout beat is accepted. The block is then idle again.
- R9: Start is ignored while a multiplication is in progress. A change of mode after start has no effect on the result.
- R10: Every register coefficient stays in [-(P-1)/2, (P-1)/2]. Every accumulator stays in [-(Q-1)/2, (Q-1)/2]. This holds even when all a and b coefficients are at their extremes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (idle only) |
| mode | input | 2 | Quotient polynomial select, sampled at start |
| load_valid | input | 1 | Load beat valid |
| load_ready | output | 1 | Block accepts a load beat |
| load_data | input | ALPHA*PW | ALPHA small coefficients, lane 0 lowest |
| b_valid | input | 1 | Large coefficient valid |
| b_ready | output | 1 | Block accepts a large coefficient |
| b_data | input | QW | One large coefficient, signed |
| r_valid | output | 1 | Result beat valid |
| r_ready | input | 1 | Sink accepts the result beat |
| r_data | output | GAMMA*QW | GAMMA result coefficients, lane 0 lowest |
| done | output | 1 | One-cycle pulse after the last result beat |

## Verification
The hardest case to reach is the x^N-x-1 feedback wrapping modulo P. For that, the top coefficient and a_0 must have the same sign and a combined magnitude above (P-1)/2, and that must happen at a step whose b value is nonzero. All-extreme operands and random operands in mode 2 drive the wrap repeatedly. An impulse in b isolates one shifted copy of a(x) so that a wrong feedback tap stands out. Random gaps on all three streams exercise the stall behaviour, and a start pulse plus a mode change in the middle of the compute phase exercise the ignore rule.

// File: rtl/polymul_pkg.sv
package polymul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_COMP = 2'd2,
    ST_READ = 2'd3
  } phase_t;

  localparam logic [1:0] RING_NEG = 2'd0;
  localparam logic [1:0] RING_CYC = 2'd1;
  localparam logic [1:0] RING_TRI = 2'd2;

  function automatic int bal_mod(input int v, input int m);
    int h;
    int r;
    h = (m - 1) / 2;
    r = v % m;
    if (r > h) r = r - m;
    if (r < -h) r = r + m;
    return r;
  endfunction
endpackage

// File: rtl/polymul_ctrl.sv
module polymul_ctrl
  import polymul_pkg::*;
#(
  parameter int N     = 8,
  parameter int ALPHA = 2,
  parameter int GAMMA = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode_in,
  input  logic                    load_valid,
  input  logic                    b_valid,
  input  logic                    r_ready,
  output logic                    load_ready,
  output logic                    b_ready,
  output logic                    r_valid,
  output logic                    load_fire,
  output logic                    b_fire,
  output logic                    r_fire,
  output logic                    clr,
  output logic [1:0]              mode_q,
  output logic [$clog2(N+1)-1:0]  rd_idx,
  output logic                    done
);
  localparam int LB = N / ALPHA;
  localparam int RB = N / GAMMA;
  localparam int CW = $clog2(N + 1);

  phase_t        state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_ready = (state_q == ST_LOAD);
  assign b_ready    = (state_q == ST_COMP);
  assign r_valid    = (state_q == ST_READ);
  assign load_fire  = load_ready && load_valid;
  assign b_fire     = b_ready && b_valid;
  assign r_fire     = r_valid && r_ready;
  assign clr        = (state_q == ST_IDLE) && start;
  assign rd_idx     = cnt_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= RING_NEG;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOAD;
          cnt_q   <= '0;
          mode_q  <= mode_in;
        end
        ST_LOAD: if (load_fire) begin
          if (cnt_q == CW'(LB - 1)) begin
            state_q <= ST_COMP;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_COMP: if (b_fire) begin
          if (cnt_q == CW'(N - 1)) begin
            state_q <= ST_READ;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_READ: if (r_fire) begin
          if (cnt_q == CW'(RB - 1)) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2 R3 R7: at most one stream handshake side is open at a time
  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ready, b_ready, r_valid}));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: last readout beat raises done
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fire && cnt_q == CW'(RB - 1)) |=> (done && !r_valid));

  // R9: sampled mode is held while busy
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(mode_q));

  // R9: start during compute does not disturb the phase
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMP && start && !b_fire) |=> (state_q == ST_COMP));
endmodule

// File: rtl/polymul_shiftreg.sv
module polymul_shiftreg
  import polymul_pkg::*;
#(
  parameter int N     = 8,
  parameter int ALPHA = 2,
  parameter int P     = 5,
  parameter int PW    = $clog2(P) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic [ALPHA*PW-1:0]      load_vec,
  input  logic                     step_en,
  input  logic [1:0]               mode,
  output logic [N-1:0][PW-1:0]     coef
);
  localparam int HP = (P - 1) / 2;

  logic [N-1:0][PW-1:0] a_q;
  logic [PW-1:0]        fb0;
  logic [PW-1:0]        fb1;

  always_comb begin
    int top;
    int s1;
    top = int'($signed(a_q[N-1]));
    s1  = int'($signed(a_q[0]));
    unique case (mode)
      RING_CYC: begin
        fb0 = PW'(top);
        fb1 = PW'(s1);
      end
      RING_TRI: begin
        fb0 = PW'(top);
        fb1 = PW'(bal_mod(s1 + top, P));
      end
      default: begin
        fb0 = PW'(-top);
        fb1 = PW'(s1);
      end
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic [PW-1:0] load_src;
    logic [PW-1:0] step_src;
    if (i < N - ALPHA) begin : g_from_reg
      assign load_src = a_q[i+ALPHA];
    end else begin : g_from_port
      assign load_src = load_vec[(i-(N-ALPHA))*PW +: PW];
    end
    if (i == 0) begin : g_tap0
      assign step_src = fb0;
    end else if (i == 1) begin : g_tap1
      assign step_src = fb1;
    end else begin : g_plain
      assign step_src = a_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q[i] <= '0;
      else if (load_en) a_q[i] <= load_src;
      else if (step_en) a_q[i] <= step_src;
    end
    // R10: shifted coefficients stay balanced mod P
    a_r10_coef_balanced: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ($signed(a_q[i]) >= -HP && $signed(a_q[i]) <= HP));
  end

  assign coef = a_q;

  // R6: two-tap feedback adds the top coefficient into position 1
  a_r6_tri_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && mode == RING_TRI) |=>
      ($signed(a_q[1]) == PW'(bal_mod(int'($signed($past(a_q[0])))
                                      + int'($signed($past(a_q[N-1]))), P))));
endmodule

// File: rtl/polymul_lane.sv
module polymul_lane #(
  parameter int P  = 5,
  parameter int Q  = 3329,
  parameter int PW = $clog2(P) + 1,
  parameter int QW = $clog2(Q) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] a_coef,
  input  logic [QW-1:0] b_coef,
  output logic [QW-1:0] acc
);
  localparam int HP = (P - 1) / 2;
  localparam int HQ = (Q - 1) / 2;

  logic [QW-1:0] acc_q;
  logic [QW-1:0] acc_d;

  always_comb begin
    int s;
    int pick;
    int cand;
    s    = int'($signed(acc_q)) + int'($signed(a_coef)) * int'($signed(b_coef));
    pick = s;
    for (int k = -HP - 1; k <= HP + 1; k++) begin
      cand = s - k * Q;
      if (cand >= -HQ && cand <= HQ) pick = cand;
    end
    acc_d = QW'(pick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R10: accumulator stays balanced mod Q
  a_r10_acc_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(acc_q) >= -HQ && $signed(acc_q) <= HQ));

  // R3: accumulator only moves on an accepted compute beat or a clear
  a_r3_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc_q));
endmodule

// File: rtl/polymul_xnet.sv
module polymul_xnet
  import polymul_pkg::*;
#(
  parameter int N     = 8,
  parameter int ALPHA = 2,
  parameter int GAMMA = 2,
  parameter int P     = 5,
  parameter int Q     = 3329
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [1:0]                           mode,
  input  logic                                 load_valid,
  output logic                                 load_ready,
  input  logic [ALPHA*($clog2(P)+1)-1:0]       load_data,
  input  logic                                 b_valid,
  output logic                                 b_ready,
  input  logic [$clog2(Q):0]                   b_data,
  output logic                                 r_valid,
  input  logic                                 r_ready,
  output logic [GAMMA*($clog2(Q)+1)-1:0]       r_data,
  output logic                                 done
);
  localparam int PW = $clog2(P) + 1;
  localparam int QW = $clog2(Q) + 1;
  localparam int CW = $clog2(N + 1);

  logic                  load_fire, b_fire, r_fire, clr;
  logic [1:0]            mode_q;
  logic [CW-1:0]         rd_idx;
  logic [N-1:0][PW-1:0]  coef;
  logic [N-1:0][QW-1:0]  acc;

  polymul_ctrl #(.N(N), .ALPHA(ALPHA), .GAMMA(GAMMA)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .load_valid(load_valid), .b_valid(b_valid), .r_ready(r_ready),
    .load_ready(load_ready), .b_ready(b_ready), .r_valid(r_valid),
    .load_fire(load_fire), .b_fire(b_fire), .r_fire(r_fire),
    .clr(clr), .mode_q(mode_q), .rd_idx(rd_idx), .done(done)
  );

  polymul_shiftreg #(.N(N), .ALPHA(ALPHA), .P(P), .PW(PW)) u_sreg (
    .clk(clk), .rst_n(rst_n), .load_en(load_fire), .load_vec(load_data),
    .step_en(b_fire), .mode(mode_q), .coef(coef)
  );

  for (genvar j = 0; j < N; j++) begin : g_lane
    polymul_lane #(.P(P), .Q(Q), .PW(PW), .QW(QW)) u_lane (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(b_fire),
      .a_coef(coef[j]), .b_coef(b_data), .acc(acc[j])
    );
  end

  always_comb begin
    r_data = '0;
    for (int g = 0; g < GAMMA; g++) begin
      int idx;
      idx = int'(rd_idx) * GAMMA + g;
      if (idx < N) r_data[g*QW +: QW] = acc[idx];
    end
  end

  // R7: presented result beat held under back-pressure
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));

  initial begin
    a_r2_divides: assert ((N % ALPHA) == 0 && (N % GAMMA) == 0 && (P % 2) == 1);
  end
endmodule

// File: tb/polymul_xnet_tb.sv
module polymul_xnet_tb_top;
  localparam int N = 8, ALPHA = 2, GAMMA = 2, P = 5, Q = 3329;
  localparam int PW = $clog2(P) + 1, QW = $clog2(Q) + 1;
  localparam int LB = N / ALPHA, RB = N / GAMMA;
  localparam int HP = (P - 1) / 2, HQ = (Q - 1) / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic load_valid = 1'b0, load_ready;
  logic [ALPHA*PW-1:0] load_data = '0;
  logic b_valid = 1'b0, b_ready;
  logic [QW-1:0] b_data = '0;
  logic r_valid, r_ready = 1'b0;
  logic [GAMMA*QW-1:0] r_data;
  logic done;

  int n_chk = 0, n_bad = 0;
  int a_v[N], b_v[N], exp_r[N];

  always #10 clk = ~clk;

  polymul_xnet #(.N(N), .ALPHA(ALPHA), .GAMMA(GAMMA), .P(P), .Q(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .done(done));

  function automatic int bmod(input int v, input int m);
    int r;
    r = v % m;
    if (r > (m - 1) / 2) r -= m;
    if (r < -((m - 1) / 2)) r += m;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // reference: accumulate b_i times the shifted small polynomial, mod P shifting
  task automatic build_ref(input int m);
    int cur[N];
    int nxt[N];
    for (int j = 0; j < N; j++) begin cur[j] = a_v[j]; exp_r[j] = 0; end
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) exp_r[j] = bmod(exp_r[j] + b_v[i] * cur[j], Q);
      for (int j = 1; j < N; j++) nxt[j] = cur[j-1];
      if (m == 1) nxt[0] = cur[N-1];
      else if (m == 2) begin nxt[0] = cur[N-1]; nxt[1] = bmod(cur[0] + cur[N-1], P); end
      else nxt[0] = -cur[N-1];
      for (int j = 0; j < N; j++) cur[j] = nxt[j];
    end
  endtask

  task automatic run_mul(input int m, input int stall, input bit poke, input string tag);
    int k;
    bit pend;
    logic [GAMMA*QW-1:0] held;
    build_ref(m);
    @(negedge clk);
    start = 1'b1; mode = 2'(m);
    @(negedge clk);
    start = 1'b0; mode = 2'($urandom % 4);   // R9: mode change after start
    chk(load_ready === 1'b1, "R2 load_ready after start", int'(load_ready), 1);
    k = 0;
    while (k < LB) begin
      load_valid = (($urandom % 100) >= stall);
      for (int j = 0; j < ALPHA; j++) load_data[j*PW +: PW] = PW'(a_v[k*ALPHA+j]);
      pend = load_valid && load_ready;
      @(negedge clk);
      if (pend) k++;
    end
    load_valid = 1'b0;
    k = 0;
    while (k < N) begin
      b_valid = (($urandom % 100) >= stall);
      b_data = QW'(b_v[k]);
      if (poke && k == N / 2) begin start = 1'b1; mode = 2'((m + 1) % 3); end
      else start = 1'b0;
      pend = b_valid && b_ready;
      @(negedge clk);
      if (poke && k == N / 2 && !pend)
        chk(b_ready === 1'b1 && load_ready === 1'b0, "R9 start ignored in compute",
            int'(load_ready), 0);
      if (pend) k++;
    end
    start = 1'b0; b_valid = 1'b0;
    k = 0; held = '0; pend = 1'b0;
    while (k < RB) begin
      if (pend)
        chk(r_valid === 1'b1 && r_data === held, "R7 stalled beat stable",
            int'(r_data[QW-1:0]), int'(held[QW-1:0]));
      r_ready = (($urandom % 100) >= stall);
      pend = r_valid && !r_ready;
      held = r_data;
      if (r_valid && r_ready) begin
        for (int g = 0; g < GAMMA; g++)
          chk($signed(r_data[g*QW +: QW]) == exp_r[k*GAMMA+g],
              $sformatf("R7 %s coef %0d", tag, k*GAMMA+g),
              int'($signed(r_data[g*QW +: QW])), exp_r[k*GAMMA+g]);
        chk(done === 1'b0, "R8 no early done", int'(done), 0);
        k++;
      end
      @(negedge clk);
    end
    r_ready = 1'b0;
    chk(done === 1'b1 && r_valid === 1'b0, "R8 done after last beat", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(load_ready === 1'b0 && b_ready === 1'b0 && r_valid === 1'b0 && done === 1'b0,
        "R1 reset outputs", int'({load_ready, b_ready, r_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(load_ready === 1'b0 && r_valid === 1'b0, "R1 idle without start",
        int'({load_ready, r_valid}), 0);

    // R4 R2: impulse at b_{N-1} exposes the negating wrap and load order
    for (int j = 0; j < N; j++) begin a_v[j] = (j % 5) - 2; b_v[j] = 0; end
    b_v[N-1] = 1;
    run_mul(0, 0, 1'b0, "R4 impulse");
    // R5: impulse at b_3 under the plain rotation
    for (int j = 0; j < N; j++) b_v[j] = (j == 3) ? 1 : 0;
    run_mul(1, 20, 1'b0, "R5 impulse");
    // R6 R10: extremes, mod-P wrap in the two-tap feedback
    for (int j = 0; j < N; j++) begin a_v[j] = HP; b_v[j] = HQ; end
    run_mul(2, 0, 1'b0, "R6 R10 max");
    for (int j = 0; j < N; j++) begin a_v[j] = -HP; b_v[j] = HQ; end
    run_mul(2, 30, 1'b0, "R6 R10 min");
    for (int j = 0; j < N; j++) begin a_v[j] = -HP; b_v[j] = -HQ; end
    run_mul(0, 0, 1'b0, "R10 neg extremes");
    // R4: mode code 3 acts as code 0
    for (int j = 0; j < N; j++) begin
      a_v[j] = int'($urandom % P) - HP; b_v[j] = int'($urandom % Q) - HQ;
    end
    run_mul(3, 25, 1'b0, "R4 code3");
    // R9: start pulse and mode change mid-compute
    run_mul(2, 10, 1'b1, "R9 poke");
    // random operands, all modes, with gaps on every stream
    for (int t = 0; t < 12; t++) begin
      for (int j = 0; j < N; j++) begin
        a_v[j] = int'($urandom % P) - HP; b_v[j] = int'($urandom % Q) - HQ;
      end
      run_mul(t % 3, 35, 1'b0, "R3 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule